// File: doc/BRIEF.md
# Masked-Write Global Control Register

This block is one 32-bit control register on a plain register bus (address, write strobe, write data, combinational read data). A write carries its own per-bit mask in the upper half: a control bit changes only if the matching mask bit is set. The rest of the word keeps its value. A single write can therefore flip one enable without a read-modify-write sequence.

The stored control word drives three groups of outputs. Two enables stop or allow the command fetch of two sequencer tasks. Four output enables drive the tri-state controls of the pin groups: external data bus, 24-pin video, 14-pin audio and 2-pin I2C. Eight transfer enables gate the raw per-channel DMA requests before they reach an arbiter. The most significant control bit is an active-low command. Writing a masked zero into it raises a global soft-reset pulse of fixed length and returns the register to its power-on value of all zeros.

A channel that is already moving data keeps its request alive through an "active" input, so its burst can complete after its enable is cleared.

Top module: `gctl_top`

## Requirements
- R1: After the reset input is released, every enable output, the soft-reset output and every gated request are 0, and a read of the register returns 0.
- R2: A write to address 0xFC updates control bit n (n = 0..13) from write data bit n only when write data bit n+16 is 1. Control bits whose mask bit is 0 keep their value.
- R3: Read data at address 0xFC returns the stored control bits in bits 13..0, with bits 31..14 always 0. At any other address the read data is 0.
- R4: A write to any address other than 0xFC changes no output.
- R5: A write to 0xFC with bit 31 = 1 and bit 15 = 0 clears all control bits at that clock edge. It also drives the soft-reset output high for exactly PULSE_LEN cycles (default 2), starting in the cycle after the write.
- R6: A write to 0xFC with bit 15 = 1, or with mask bit 31 = 0, produces no soft-reset pulse.
- R7: Writes to 0xFC are ignored while the soft-reset output is high.
- R8: The sequencer enables follow the stored bits: seq_en_o[1] is bit 13 (task 1) and seq_en_o[0] is bit 12 (task 0).
- R9: The pin-group output enables follow stored bits 11..8. pin_oe_o[3] is bit 11 (external data bus port), [2] is bit 10 (video port), [1] is bit 9 (audio port) and [0] is bit 8 (I2C port). A 0 means the group is high-impedance.
- R10: xfer_en_o[n] equals stored bit n for n = 7..0. The channel order is: bit 7 external data bus, bits 6..4 video channels 1..3, bit 3 audio 2 out, bit 2 audio 2 in, bit 1 audio 1 out, bit 0 audio 1 in.
- R11: chan_req_o[n] is 1 exactly when chan_req_i[n] is 1 and either xfer_en_o[n] or chan_active_i[n] is 1.
- R12: Bit 14 stores nothing. Writing 1 to it with its mask set reads back as 0 and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: mask in 31..16, control word in 15..0 |
| bus_rdata | output | 32 | Read data for the current address |
| chan_req_i | input | 8 | Raw transfer requests per channel |
| chan_active_i | input | 8 | Channel has a transfer in progress |
| soft_rst_o | output | 1 | Global soft-reset pulse, active high |
| seq_en_o | output | 2 | Sequencer task enables |
| pin_oe_o | output | 4 | Pin-group output enables |
| xfer_en_o | output | 8 | Per-channel transfer enables |
| chan_req_o | output | 8 | Qualified requests toward the arbiter |

## Verification
The assertions check every cycle that:
- the read word's upper bits are zero and its lower bits mirror the enable outputs;
- the outputs hold when no write hits the register or while the pulse runs;
- unmasked bits survive a write;
- the reset command is followed by a cleared word and a pulse of exactly the set length;
- gated requests never appear without a raw request backed by an enable or an active transfer.

Only the bench scenarios show the specific bit-to-output mapping against expected constants, that bit 14 never sticks, and that a write landing in the middle of a pulse really is lost. They also show that long random mixes of masks, stray addresses and reset commands leave the word where an independent model puts it.

// File: rtl/gctl_pkg.sv
package gctl_pkg;
  localparam int DATA_W   = 32;
  localparam int MASK_LSB = 16;
  localparam int BIT_NRST = 15;
  localparam int SEQ_N    = 2;
  localparam int PIN_N    = 4;
  localparam int CH_N     = 8;
  localparam int STORE_W  = SEQ_N + PIN_N + CH_N;

  // stored control bits, most significant first: seq, pins, channels
  typedef struct packed {
    logic [SEQ_N-1:0] seq;
    logic [PIN_N-1:0] pin;
    logic [CH_N-1:0]  xfer;
  } ctrl_t;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_UPDATE = 2'd1,
    WR_RESET  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/gctl_rst_sync.sv
module gctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_core_n = stage2_q;
endmodule

// File: rtl/gctl_wr_decode.sv
module gctl_wr_decode
  import gctl_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFC
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               pulse_busy,
  output wr_kind_e           wr_kind,
  output logic [STORE_W-1:0] upd_mask,
  output logic [STORE_W-1:0] upd_val
);
  logic addr_hit;
  logic wr_hit;
  logic nrst_masked;
  logic nrst_low;
  logic unused_rsvd;

  // bit 14 and its mask carry no state
  assign unused_rsvd = ^{bus_wdata[MASK_LSB+BIT_NRST-1], bus_wdata[BIT_NRST-1]};

  always_comb begin
    addr_hit    = (bus_addr == CTRL_ADDR);
    wr_hit      = bus_wr && addr_hit && !pulse_busy;
    nrst_masked = bus_wdata[MASK_LSB+BIT_NRST];
    nrst_low    = !bus_wdata[BIT_NRST];
    upd_mask    = bus_wdata[MASK_LSB +: STORE_W];
    upd_val     = bus_wdata[STORE_W-1:0];
    wr_kind     = WR_NONE;
    if (wr_hit) begin
      if (nrst_masked && nrst_low) wr_kind = WR_RESET;
      else                         wr_kind = WR_UPDATE;
    end
  end
endmodule

// File: rtl/gctl_store.sv
module gctl_store
  import gctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wr_kind_e           wr_kind,
  input  logic [STORE_W-1:0] upd_mask,
  input  logic [STORE_W-1:0] upd_val,
  output logic [STORE_W-1:0] ctrl_q
);
  logic [STORE_W-1:0] ctrl_d;
  logic               ctrl_en;

  always_comb begin
    ctrl_en = 1'b0;
    ctrl_d  = ctrl_q;
    case (wr_kind)
      WR_RESET: begin
        ctrl_en = 1'b1;
        ctrl_d  = '0;
      end
      WR_UPDATE: begin
        ctrl_en = 1'b1;
        ctrl_d  = (ctrl_q & ~upd_mask) | (upd_val & upd_mask);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/gctl_pulse.sv
module gctl_pulse #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/gctl_req_gate.sv
module gctl_req_gate #(
  parameter int CH_N = 8
) (
  input  logic [CH_N-1:0] raw_req,
  input  logic [CH_N-1:0] xfer_en,
  input  logic [CH_N-1:0] active,
  output logic [CH_N-1:0] req_o
);
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    assign req_o[ch] = raw_req[ch] & (xfer_en[ch] | active[ch]);
  end
endmodule

// File: rtl/gctl_top.sv
module gctl_top
  import gctl_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFC,
  parameter int                PULSE_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CH_N-1:0]   chan_req_i,
  input  logic [CH_N-1:0]   chan_active_i,
  output logic              soft_rst_o,
  output logic [SEQ_N-1:0]  seq_en_o,
  output logic [PIN_N-1:0]  pin_oe_o,
  output logic [CH_N-1:0]   xfer_en_o,
  output logic [CH_N-1:0]   chan_req_o
);
  logic               rst_core_n;
  wr_kind_e           wr_kind;
  logic [STORE_W-1:0] upd_mask;
  logic [STORE_W-1:0] upd_val;
  logic [STORE_W-1:0] ctrl_q;
  ctrl_t              ctrl_s;
  logic               pulse_start;

  gctl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gctl_wr_decode #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_decode (
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .pulse_busy (soft_rst_o),
    .wr_kind    (wr_kind),
    .upd_mask   (upd_mask),
    .upd_val    (upd_val)
  );

  gctl_store u_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_kind  (wr_kind),
    .upd_mask (upd_mask),
    .upd_val  (upd_val),
    .ctrl_q   (ctrl_q)
  );

  assign pulse_start = (wr_kind == WR_RESET);

  gctl_pulse #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (pulse_start),
    .pulse_o (soft_rst_o)
  );

  assign ctrl_s    = ctrl_t'(ctrl_q);
  assign seq_en_o  = ctrl_s.seq;
  assign pin_oe_o  = ctrl_s.pin;
  assign xfer_en_o = ctrl_s.xfer;

  gctl_req_gate #(
    .CH_N (CH_N)
  ) u_gate (
    .raw_req (chan_req_i),
    .xfer_en (ctrl_s.xfer),
    .active  (chan_active_i),
    .req_o   (chan_req_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) bus_rdata[STORE_W-1:0] = ctrl_q;
  end
endmodule

// File: rtl/gctl_checker.sv
module gctl_checker
  import gctl_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFC,
  parameter int                PULSE_LEN = 2
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CH_N-1:0]   chan_req_i,
  input logic [CH_N-1:0]   chan_active_i,
  input logic              soft_rst_o,
  input logic [SEQ_N-1:0]  seq_en_o,
  input logic [PIN_N-1:0]  pin_oe_o,
  input logic [CH_N-1:0]   xfer_en_o,
  input logic [CH_N-1:0]   chan_req_o
);
  logic [STORE_W-1:0] outs;
  logic [STORE_W-1:0] wmask;
  logic               hit;
  logic               cmd;
  logic [31:0]        run_q;

  assign outs  = {seq_en_o, pin_oe_o, xfer_en_o};
  assign wmask = bus_wdata[MASK_LSB +: STORE_W];
  assign hit   = bus_wr && (bus_addr == CTRL_ADDR) && !soft_rst_o;
  assign cmd   = hit && bus_wdata[MASK_LSB+BIT_NRST] && !bus_wdata[BIT_NRST];

  // cycles of pulse already seen before the current one
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)     run_q <= '0;
    else if (soft_rst_o) run_q <= run_q + 1;
    else                 run_q <= '0;
  end

  assert_rd_upper_zero_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    bus_rdata[DATA_W-1:STORE_W] == '0);
  assert_rd_other_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr != CTRL_ADDR) |-> bus_rdata == '0);
  assert_readback_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr == CTRL_ADDR) |-> bus_rdata[STORE_W-1:0] == outs);
  assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(bus_wr && bus_addr == CTRL_ADDR) |=> $stable(outs));
  assert_keep_unmasked_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (hit && !cmd) |=> ((outs & ~$past(wmask)) == ($past(outs) & ~$past(wmask))));
  assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    cmd |=> soft_rst_o);
  assert_cmd_clear_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    cmd |=> outs == '0);
  assert_pulse_max_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    soft_rst_o |-> run_q < PULSE_LEN);
  assert_pulse_full_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(soft_rst_o) |-> run_q == PULSE_LEN);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(soft_rst_o) |-> $past(cmd));
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    soft_rst_o |=> $stable(outs));
  assert_gate_block_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (chan_req_o & ~(chan_req_i & (xfer_en_o | chan_active_i))) == '0);
  assert_gate_pass_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((chan_req_i & (xfer_en_o | chan_active_i)) & ~chan_req_o) == '0);
endmodule

bind gctl_top gctl_checker #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .PULSE_LEN (PULSE_LEN)
) u_gctl_checker (
  .clk           (clk),
  .core_rst_n    (rst_core_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .chan_req_i    (chan_req_i),
  .chan_active_i (chan_active_i),
  .soft_rst_o    (soft_rst_o),
  .seq_en_o      (seq_en_o),
  .pin_oe_o      (pin_oe_o),
  .xfer_en_o     (xfer_en_o),
  .chan_req_o    (chan_req_o)
);

// File: tb/test_gctl_top.sv
`timescale 1ns/1ps
module test_gctl_top;
  localparam logic [7:0] REG_A = 8'hFC;
  localparam int PLEN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  chan_req_i = '0;
  logic [7:0]  chan_active_i = '0;
  logic        soft_rst_o;
  logic [1:0]  seq_en_o;
  logic [3:0]  pin_oe_o;
  logic [7:0]  xfer_en_o;
  logic [7:0]  chan_req_o;

  int compared = 0;
  int mismatched = 0;
  logic [13:0] m_ctrl = '0;
  int m_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gctl_top i_gctl_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_req_i(chan_req_i),
    .chan_active_i(chan_active_i), .soft_rst_o(soft_rst_o), .seq_en_o(seq_en_o),
    .pin_oe_o(pin_oe_o), .xfer_en_o(xfer_en_o), .chan_req_o(chan_req_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [13:0] c);
    return (a == REG_A) ? {18'b0, c} : 32'b0;
  endfunction

  function automatic logic [7:0] exp_req(input logic [7:0] r, input logic [7:0] en, input logic [7:0] act);
    logic [7:0] q;
    for (int i = 0; i < 8; i++) q[i] = r[i] && (en[i] || act[i]);
    return q;
  endfunction

  // one bus cycle; model follows the requirements, outputs compared after the edge
  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [7:0] rq, input logic [7:0] act);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; chan_req_i = rq; chan_active_i = act;
    @(posedge clk);
    if (wr && a == REG_A && m_cnt == 0) begin
      if (d[31] && !d[15]) begin
        m_ctrl = '0;        // R5
        m_cnt  = PLEN;
      end else begin
        m_ctrl = (m_ctrl & ~d[29:16]) | (d[13:0] & d[29:16]);  // R2, R12
      end
    end else if (m_cnt > 0) begin
      m_cnt--;
    end
    #2;
    check("R5 soft_rst_o", {31'b0, soft_rst_o}, {31'b0, m_cnt != 0});
    check("R8 seq_en_o", {30'b0, seq_en_o}, {30'b0, m_ctrl[13:12]});
    check("R9 pin_oe_o", {28'b0, pin_oe_o}, {28'b0, m_ctrl[11:8]});
    check("R10 xfer_en_o", {24'b0, xfer_en_o}, {24'b0, m_ctrl[7:0]});
    check("R11 chan_req_o", {24'b0, chan_req_o}, {24'b0, exp_req(rq, m_ctrl[7:0], act)});
    check("R3 bus_rdata", bus_rdata, exp_rd(a, m_ctrl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state
    cyc(1'b0, REG_A, 32'h0, 8'hFF, 8'h00);
    check("R1 all enables", {18'b0, seq_en_o, pin_oe_o, xfer_en_o}, 32'h0);
    check("R1 requests", {24'b0, chan_req_o}, 32'h0);
    check("R1 soft reset", {31'b0, soft_rst_o}, 32'h0);
    // R8 R9 R10: set every stored bit
    cyc(1'b1, REG_A, 32'h3FFF_3FFF, 8'h00, 8'h00);
    check("R8 seq both", {30'b0, seq_en_o}, 32'h3);
    check("R9 pins all", {28'b0, pin_oe_o}, 32'hF);
    check("R10 chans all", {24'b0, xfer_en_o}, 32'hFF);
    // R2: clear only bits 7..4
    cyc(1'b1, REG_A, 32'h00F0_0000, 8'h00, 8'h00);
    check("R2 partial mask", {18'b0, seq_en_o, pin_oe_o, xfer_en_o}, 32'h3F0F);
    // R4: other address write, then read there
    cyc(1'b1, 8'hF8, 32'hFFFF_0000, 8'h00, 8'h00);
    check("R4 stray write", {24'b0, xfer_en_o}, 32'h0F);
    check("R3 stray read", bus_rdata, 32'h0);
    // R12: reserved bit
    cyc(1'b1, REG_A, 32'h4000_4000, 8'h00, 8'h00);
    check("R12 bit14 read", {31'b0, bus_rdata[14]}, 32'h0);
    check("R12 unchanged", bus_rdata, 32'h0000_3F0F);
    // R6: no pulse without masked zero
    cyc(1'b1, REG_A, 32'h8000_8000, 8'h00, 8'h00);
    check("R6 masked one", {31'b0, soft_rst_o}, 32'h0);
    cyc(1'b1, REG_A, 32'h0000_0000, 8'h00, 8'h00);
    check("R6 unmasked zero", {31'b0, soft_rst_o}, 32'h0);
    // R11: gating with and without active transfers
    cyc(1'b0, REG_A, 32'h0, 8'hFF, 8'h00);
    check("R11 enabled only", {24'b0, chan_req_o}, 32'h0F);
    cyc(1'b0, REG_A, 32'h0, 8'hFF, 8'hF0);
    check("R11 active keeps", {24'b0, chan_req_o}, 32'hFF);
    // R5 and R7: reset command, write during pulse is lost
    cyc(1'b1, REG_A, 32'h8000_0000, 8'h00, 8'h00);
    check("R5 pulse cycle 1", {31'b0, soft_rst_o}, 32'h1);
    check("R5 cleared", bus_rdata, 32'h0);
    cyc(1'b1, REG_A, 32'hFFFF_3FFF, 8'h00, 8'h00);
    check("R5 pulse cycle 2", {31'b0, soft_rst_o}, 32'h1);
    cyc(1'b0, REG_A, 32'h0, 8'h00, 8'h00);
    check("R5 pulse ended", {31'b0, soft_rst_o}, 32'h0);
    check("R7 write ignored", bus_rdata, 32'h0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : REG_A;
      cyc(1'($urandom % 3 != 0), a, $urandom, 8'($urandom), 8'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule